// File: doc/BRIEF.md
# Serial Programming Command Interface

This block is the target side of an in-system programming link. A host shifts four-byte instructions in on a serial data line, timed by a serial clock that the block oversamples with its own system clock. The block frames each instruction, returns every received byte on its serial output during the byte that follows, and forwards decoded commands to a memory back end. A command carries an opcode, an address and a data byte, and it is handed over on a valid/ready handshake.

The target reset pin is active low. While it is high, the block holds its framing counters, echo path and enable state cleared. Once it is low, the host must send an enable instruction before any command is forwarded. During that enable instruction the key byte returns on the serial output while the third byte is being shifted in. The host uses this to confirm that framing is aligned. If the echo is wrong, the host pulses the reset pin high and tries again.

Top module: `isp_cmd_if`

## Requirements
- R1: An instruction is 32 bits, sent most significant bit first and captured on rising serial-clock edges. Byte 1 becomes the opcode, bytes 2 and 3 form the address (byte 2 is the upper half), and byte 4 becomes the data.
- R2: While programming is not enabled, every instruction other than the enable instruction is dropped, and `cmdValid` stays low.
- R3: The instruction with opcode 0xAC and second byte 0x53 enables programming, and its third and fourth bytes are don't-care. After it, all other instructions are forwarded. The enable instruction itself is never forwarded.
- R4: Each completed byte is driven back on `misoOut` during the next byte, most significant bit first, changing only on falling serial-clock edges. In the enable instruction this puts 0x53 on the line during byte 3.
- R5: All four bytes of an instruction are consumed even when its second byte is wrong. Programming then stays disabled, and the next instruction is framed from its first bit.
- R6: While `tgtRstN` is high, the bit counter is zero, programming is disabled, any pending command is withdrawn, `busyErr` is cleared and `misoOut` is 0.
- R7: While `cmdValid` is high and `cmdReady` is low, `cmdValid` and the command fields hold steady. A cycle with both high transfers the command.
- R8: A forwardable instruction that completes while a command is still waiting is dropped. It sets `busyErr`, which stays high until the reset pin goes high.
- R9: Serial clock phases of three system clocks or longer are captured correctly. All three pins pass a two-stage synchroniser first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| sysRstN | input | 1 | Active-low system reset |
| tgtRstN | input | 1 | Target reset pin; low selects programming mode |
| sckIn | input | 1 | Serial clock from the host |
| mosiIn | input | 1 | Serial data from the host |
| misoOut | output | 1 | Serial echo data to the host |
| cmdValid | output | 1 | Command available to the back end |
| cmdReady | input | 1 | Back end accepts the command |
| cmdOpcode | output | 8 | Command opcode (byte 1) |
| cmdAddr | output | 16 | Command address (bytes 2 and 3) |
| cmdData | output | 8 | Command data (byte 4) |
| busyErr | output | 1 | Sticky flag: instruction dropped because the back end was busy |

## Verification
A bit counter that drifts shows up within one byte as a wrong echo on `misoOut`: the 0x53 key comes back shifted or missing during the third byte of the enable instruction. The same drift also makes the decoded fields carry bytes that straddle instruction boundaries. An enable flag that is set wrongly or left standing shows as `cmdValid` rising after an instruction that should have been dropped, a few system clocks after its last rising edge. A handshake fault shows as fields that change while waiting, or as `busyErr` failing to rise on an overrun.

// File: rtl/isp_cmd_pkg.sv
package isp_cmd_pkg;
  localparam logic [7:0] ENABLE_OP  = 8'hAC;
  localparam logic [7:0] ENABLE_KEY = 8'h53;

  typedef struct packed {
    logic clear;     // reset pin high: hold everything cleared
    logic shiftIn;   // rising serial clock: take one bit
    logic shiftOut;  // falling serial clock: present next echo bit
    logic echoLoad;  // a byte just completed
    logic frameEnd;  // an instruction just completed
  } ispStrobe_t;
endpackage

// File: rtl/isp_cmd_ctl.sv
module isp_cmd_ctl
  import isp_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8,
  parameter int INSTR_BYTES = 4,
  localparam int FRAME_BITS = BYTE_W * INSTR_BYTES,
  localparam int CNT_W      = $clog2(FRAME_BITS),
  localparam int LOW_W      = $clog2(BYTE_W)
) (
  input  logic             clk,
  input  logic             sysRstN,
  input  logic             tgtRstN,
  input  logic             sckIn,
  input  logic             mosiIn,
  output ispStrobe_t       strb,
  output logic             mosiBit,
  output logic [CNT_W-1:0] bitCnt
);
  logic [SYNC_STAGES-1:0] sckQ, mosiQ, rstQ;
  logic sckPrev, sckRise, sckFall, lastBit;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      sckQ    <= '0;
      mosiQ   <= '0;
      rstQ    <= '1;
      sckPrev <= 1'b0;
    end else begin
      sckQ    <= {sckQ[SYNC_STAGES-2:0], sckIn};
      mosiQ   <= {mosiQ[SYNC_STAGES-2:0], mosiIn};
      rstQ    <= {rstQ[SYNC_STAGES-2:0], tgtRstN};
      sckPrev <= sckQ[SYNC_STAGES-1];
    end
  end

  assign sckRise = sckQ[SYNC_STAGES-1] & ~sckPrev;
  assign sckFall = ~sckQ[SYNC_STAGES-1] & sckPrev;
  assign mosiBit = mosiQ[SYNC_STAGES-1];
  assign lastBit = (bitCnt == CNT_W'(FRAME_BITS - 1));

  always_comb begin
    strb.clear    = rstQ[SYNC_STAGES-1];
    strb.shiftIn  = sckRise & ~strb.clear;
    strb.shiftOut = sckFall & ~strb.clear;
    strb.echoLoad = strb.shiftIn & (&bitCnt[LOW_W-1:0]);
    strb.frameEnd = strb.shiftIn & lastBit;
  end

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN)           bitCnt <= '0;
    else if (strb.clear)    bitCnt <= '0;
    else if (strb.shiftIn)  bitCnt <= lastBit ? '0 : bitCnt + 1'b1;
  end
endmodule

// File: rtl/isp_cmd_dp.sv
module isp_cmd_dp
  import isp_cmd_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int INSTR_BYTES = 4,
  localparam int FRAME_BITS = BYTE_W * INSTR_BYTES
) (
  input  logic                  clk,
  input  logic                  sysRstN,
  input  ispStrobe_t            strb,
  input  logic                  mosiBit,
  output logic [FRAME_BITS-1:0] frameWord,
  output logic                  misoOut
);
  logic [FRAME_BITS-2:0] shiftReg;
  logic [BYTE_W-1:0]     echoReg;

  assign frameWord = {shiftReg, mosiBit};

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      shiftReg <= '0;
      echoReg  <= '0;
      misoOut  <= 1'b0;
    end else if (strb.clear) begin
      shiftReg <= '0;
      echoReg  <= '0;
      misoOut  <= 1'b0;
    end else begin
      if (strb.shiftIn) shiftReg <= frameWord[FRAME_BITS-2:0];
      if (strb.echoLoad) echoReg <= frameWord[BYTE_W-1:0];
      else if (strb.shiftOut) begin
        misoOut <= echoReg[BYTE_W-1];
        echoReg <= {echoReg[BYTE_W-2:0], 1'b0};
      end
    end
  end
endmodule

// File: rtl/isp_cmd_dec.sv
module isp_cmd_dec
  import isp_cmd_pkg::*;
#(
  parameter int BYTE_W      = 8,
  parameter int INSTR_BYTES = 4,
  localparam int FRAME_BITS = BYTE_W * INSTR_BYTES,
  localparam int ADDR_W     = (INSTR_BYTES - 2) * BYTE_W
) (
  input  logic                  clk,
  input  logic                  sysRstN,
  input  ispStrobe_t            strb,
  input  logic [FRAME_BITS-1:0] frameWord,
  input  logic                  cmdReady,
  output logic                  cmdValid,
  output logic [BYTE_W-1:0]     cmdOpcode,
  output logic [ADDR_W-1:0]     cmdAddr,
  output logic [BYTE_W-1:0]     cmdData,
  output logic                  busyErr
);
  logic enabled, isEnable, waiting;
  logic [BYTE_W-1:0] opByte, keyByte;

  assign opByte   = frameWord[FRAME_BITS-1 -: BYTE_W];
  assign keyByte  = frameWord[FRAME_BITS-BYTE_W-1 -: BYTE_W];
  assign isEnable = (opByte == ENABLE_OP) && (keyByte == ENABLE_KEY);
  assign waiting  = cmdValid & ~cmdReady;

  always_ff @(posedge clk or negedge sysRstN) begin
    if (!sysRstN) begin
      enabled   <= 1'b0;
      cmdValid  <= 1'b0;
      busyErr   <= 1'b0;
      cmdOpcode <= '0;
      cmdAddr   <= '0;
      cmdData   <= '0;
    end else if (strb.clear) begin
      enabled  <= 1'b0;
      cmdValid <= 1'b0;
      busyErr  <= 1'b0;
    end else begin
      if (cmdValid && cmdReady) cmdValid <= 1'b0;
      if (strb.frameEnd) begin
        if (isEnable) enabled <= 1'b1;
        else if (enabled) begin
          if (waiting) busyErr <= 1'b1;
          else begin
            cmdValid  <= 1'b1;
            cmdOpcode <= opByte;
            cmdAddr   <= frameWord[BYTE_W +: ADDR_W];
            cmdData   <= frameWord[BYTE_W-1:0];
          end
        end
      end
    end
  end
endmodule

// File: rtl/isp_cmd_if.sv
module isp_cmd_if
  import isp_cmd_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int BYTE_W      = 8,
  parameter int INSTR_BYTES = 4,
  localparam int FRAME_BITS = BYTE_W * INSTR_BYTES,
  localparam int CNT_W      = $clog2(FRAME_BITS),
  localparam int ADDR_W     = (INSTR_BYTES - 2) * BYTE_W
) (
  input  logic              clk,
  input  logic              sysRstN,
  input  logic              tgtRstN,
  input  logic              sckIn,
  input  logic              mosiIn,
  output logic              misoOut,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [BYTE_W-1:0] cmdOpcode,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [BYTE_W-1:0] cmdData,
  output logic              busyErr
);
  ispStrobe_t            strb;
  logic                  mosiBit;
  logic [CNT_W-1:0]      bitCnt;
  logic [FRAME_BITS-1:0] frameWord;

  isp_cmd_ctl #(.SYNC_STAGES(SYNC_STAGES), .BYTE_W(BYTE_W), .INSTR_BYTES(INSTR_BYTES)) ctl_i (
    .clk(clk), .sysRstN(sysRstN), .tgtRstN(tgtRstN), .sckIn(sckIn), .mosiIn(mosiIn),
    .strb(strb), .mosiBit(mosiBit), .bitCnt(bitCnt));

  isp_cmd_dp #(.BYTE_W(BYTE_W), .INSTR_BYTES(INSTR_BYTES)) dp_i (
    .clk(clk), .sysRstN(sysRstN), .strb(strb), .mosiBit(mosiBit),
    .frameWord(frameWord), .misoOut(misoOut));

  isp_cmd_dec #(.BYTE_W(BYTE_W), .INSTR_BYTES(INSTR_BYTES)) dec_i (
    .clk(clk), .sysRstN(sysRstN), .strb(strb), .frameWord(frameWord), .cmdReady(cmdReady),
    .cmdValid(cmdValid), .cmdOpcode(cmdOpcode), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .busyErr(busyErr));
endmodule

// File: rtl/isp_cmd_chk.sv
module isp_cmd_chk
  import isp_cmd_pkg::*;
#(
  parameter int CNT_W  = 5,
  parameter int BYTE_W = 8,
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              sysRstN,
  input logic              misoOut,
  input logic              cmdValid,
  input logic              cmdReady,
  input logic [BYTE_W-1:0] cmdOpcode,
  input logic [ADDR_W-1:0] cmdAddr,
  input logic [BYTE_W-1:0] cmdData,
  input logic              busyErr,
  input ispStrobe_t        strb,
  input logic [CNT_W-1:0]  bitCnt
);
  // R7: a waiting command holds its fields
  assert_cmd_hold_R7: assert property (@(posedge clk) disable iff (!sysRstN)
    (cmdValid && !cmdReady && !strb.clear) |=>
      (cmdValid && $stable(cmdOpcode) && $stable(cmdAddr) && $stable(cmdData)));

  // R8: the overrun flag is sticky until the reset pin clears it
  assert_err_sticky_R8: assert property (@(posedge clk) disable iff (!sysRstN)
    (busyErr && !strb.clear) |=> busyErr);

  // R6: the reset pin clears framing and the command path
  assert_clear_state_R6: assert property (@(posedge clk) disable iff (!sysRstN)
    strb.clear |=> (bitCnt == '0 && !cmdValid && !misoOut && !busyErr));

  // R4: the echo output moves only on a falling serial clock
  assert_miso_fall_only_R4: assert property (@(posedge clk) disable iff (!sysRstN)
    (!strb.shiftOut && !strb.clear) |=> $stable(misoOut));

  // R1: a command appears only right after an instruction completes
  assert_valid_after_frame_R1: assert property (@(posedge clk) disable iff (!sysRstN)
    $rose(cmdValid) |-> $past(strb.frameEnd));
endmodule

bind isp_cmd_if isp_cmd_chk chk_i (
  .clk(clk), .sysRstN(sysRstN), .misoOut(misoOut), .cmdValid(cmdValid),
  .cmdReady(cmdReady), .cmdOpcode(cmdOpcode), .cmdAddr(cmdAddr), .cmdData(cmdData),
  .busyErr(busyErr), .strb(strb), .bitCnt(bitCnt));

// File: tb/isp_cmd_if_tb.sv
module isp_cmd_if_tb_top;
  logic clk = 1'b0;
  logic sysRstN = 1'b0, tgtRstN = 1'b1, sckIn = 1'b0, mosiIn = 1'b0, cmdReady = 1'b0;
  logic misoOut, cmdValid, busyErr;
  logic [7:0] cmdOpcode, cmdData;
  logic [15:0] cmdAddr;
  int checks = 0, errors = 0;
  int phase = 4;
  logic [7:0] echo [4];

  always #10 clk = ~clk;

  isp_cmd_if dut_i (
    .clk(clk), .sysRstN(sysRstN), .tgtRstN(tgtRstN), .sckIn(sckIn), .mosiIn(mosiIn),
    .misoOut(misoOut), .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOpcode(cmdOpcode),
    .cmdAddr(cmdAddr), .cmdData(cmdData), .busyErr(busyErr));

  function automatic logic [15:0] expAddr(input logic [7:0] hi, input logic [7:0] lo);
    return {hi, lo};
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic [7:0] got);
    for (int i = 7; i >= 0; i--) begin
      sckIn = 1'b0;
      mosiIn = b[i];
      wait_clk(phase);
      got[i] = misoOut;
      sckIn = 1'b1;
      wait_clk(phase);
    end
  endtask

  task automatic send_instr(input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] b2, input logic [7:0] b3);
    logic [7:0] g;
    send_byte(b0, g); echo[0] = g;
    send_byte(b1, g); echo[1] = g;
    send_byte(b2, g); echo[2] = g;
    send_byte(b3, g); echo[3] = g;
    wait_clk(6);
  endtask

  task automatic accept();
    cmdReady = 1'b1;
    wait_clk(1);
    cmdReady = 1'b0;
  endtask

  task automatic pulse_reset();
    sckIn = 1'b0;
    wait_clk(4);
    tgtRstN = 1'b1;
    wait_clk(6);
    check(busyErr == 1'b0 && cmdValid == 1'b0 && misoOut == 1'b0, "R6 clear on pulse",
          {busyErr, cmdValid, misoOut}, 0);
    tgtRstN = 1'b0;
    wait_clk(6);
  endtask

  initial begin
    logic [7:0] op, a1, a2, d, g;
    void'($urandom(32'd7321));
    wait_clk(3);
    sysRstN = 1'b1;
    wait_clk(4);
    check(misoOut == 1'b0 && cmdValid == 1'b0 && busyErr == 1'b0, "R6 reset state",
          {misoOut, cmdValid, busyErr}, 0);
    tgtRstN = 1'b0;
    wait_clk(6);

    // R2: command before enable is dropped
    send_instr(8'h20, 8'h01, 8'h02, 8'h03);
    check(cmdValid == 1'b0, "R2 dropped before enable", cmdValid, 0);

    // R5: wrong key, all four bytes consumed, stays disabled
    send_instr(8'hAC, 8'h52, 8'h00, 8'h00);
    check(echo[2] == 8'h52, "R5 echo of wrong key", echo[2], 8'h52);
    send_instr(8'h40, 8'h00, 8'h10, 8'h55);
    check(cmdValid == 1'b0, "R5 still disabled", cmdValid, 0);

    // R3 / R4: enable handshake with key echo
    send_instr(8'hAC, 8'h53, 8'h00, 8'h00);
    check(echo[2] == 8'h53, "R4 key echo in byte 3", echo[2], 8'h53);
    check(echo[1] == 8'hAC, "R4 opcode echo in byte 2", echo[1], 8'hAC);
    check(cmdValid == 1'b0, "R3 enable not forwarded", cmdValid, 0);

    // R1 / R7 / R4: random forwarded commands
    for (int k = 0; k < 20; k++) begin
      phase = 4 + int'($urandom_range(2));
      op = 8'($urandom_range(255));
      if (op == 8'hAC) op = 8'h4C;
      a1 = 8'($urandom_range(255));
      a2 = 8'($urandom_range(255));
      d  = 8'($urandom_range(255));
      send_instr(op, a1, a2, d);
      check(cmdValid == 1'b1, "R3 forwarded after enable", cmdValid, 1);
      check(cmdOpcode == op && cmdAddr == expAddr(a1, a2) && cmdData == d, "R1 fields",
            {cmdOpcode, cmdAddr, cmdData}, {op, expAddr(a1, a2), d});
      check(echo[1] == op && echo[2] == a1 && echo[3] == a2, "R4 echo bytes",
            {echo[1], echo[2], echo[3]}, {op, a1, a2});
      wait_clk(int'($urandom_range(5)) + 2);
      check(cmdValid == 1'b1 && cmdData == d, "R7 held while not ready", cmdData, d);
      accept();
      check(cmdValid == 1'b0, "R7 transfer on ready", cmdValid, 0);
    end

    // R8: overrun sets sticky error, first command kept
    phase = 4;
    send_instr(8'h11, 8'h22, 8'h33, 8'h44);
    send_instr(8'h55, 8'h66, 8'h77, 8'h88);
    check(busyErr == 1'b1, "R8 overrun flag", busyErr, 1);
    check(cmdOpcode == 8'h11 && cmdData == 8'h44, "R8 first command kept",
          {cmdOpcode, cmdData}, 16'h1144);
    accept();
    wait_clk(3);
    check(busyErr == 1'b1 && cmdValid == 1'b0, "R8 flag sticky", {busyErr, cmdValid}, 2'b10);

    // R6: pulse clears enable
    pulse_reset();
    send_instr(8'h20, 8'h01, 8'h02, 8'h03);
    check(cmdValid == 1'b0, "R6 enable cleared", cmdValid, 0);

    // R6: desync by partial byte, pulse realigns
    for (int i = 0; i < 5; i++) begin
      sckIn = 1'b0; mosiIn = 1'b1; wait_clk(phase);
      sckIn = 1'b1; wait_clk(phase);
    end
    pulse_reset();
    // R9: minimum phase length
    phase = 3;
    send_instr(8'hAC, 8'h53, 8'h9A, 8'h00);
    check(echo[2] == 8'h53, "R9 R6 key echo after realign", echo[2], 8'h53);
    send_instr(8'hC0, 8'h01, 8'hFE, 8'h5A);
    check(cmdValid == 1'b1 && cmdOpcode == 8'hC0 && cmdAddr == 16'h01FE && cmdData == 8'h5A,
          "R9 fields at short phase", {cmdOpcode, cmdAddr, cmdData}, 32'hC001FE5A);
    accept();
    send_byte(8'h00, g);
    check(g == 8'h5A, "R4 echo of last byte", g, 8'h5A);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule